// File: doc/BRIEF.md
# Byte-wide to serial configuration loader

This block loads a programmable device that expects its configuration as a serial bitstream in slave-serial mode. The bytes come from a parallel byte-wide memory. The block drives the memory address and reads one byte per eight clocks. It sends each byte's bits on a serial data pin, least significant bit first. It also supplies the configuration clock that goes with the data. The clock is the inverted system clock, so the target samples each data bit in the middle of its valid window.

Each byte is split into two nibble holding registers that work in ping-pong fashion. While one nibble is shifted out, the other is reloaded from the memory. The serial stream therefore has no gaps at nibble or byte boundaries.

The target reports its status on two inputs, a ready/error line and a done line. If the ready line drops during loading, the block aborts. It pulses the active-low program output for one cycle and goes back to idle. When the ready line returns, loading restarts from address zero. When the target reports done, the block gives a fixed number of extra clocks and then disables the clock driver. An external pull-down then holds the clock line low.

Top module: `cfg_serial_loader`

## Requirements
- R1: After synchronous reset, `prog_n` is 1, `cclk_en` is 0 and `mem_addr` is 0.
- R2: Loading starts on the cycle after `init_n`=1 and `done_in`=0 are seen in idle. While idle with `init_n`=0 or `done_in`=1, `cclk_en` stays 0 and `mem_addr` stays 0.
- R3: Byte k of the memory appears on `sdo` with bit 0 first and bit 7 last. Consecutive bytes follow each other, one bit per enabled clock, with no gap. The first enabled clock already carries bit 0 of byte 0.
- R4: For stream bit i, `mem_addr` equals i/8 while bits 0..3 of a byte are sent and i/8+1 while bits 4..7 are sent. The address therefore increments exactly once per byte, after the low nibble.
- R5: When `done_in` is 1 during shifting, exactly TAIL_CLKS more enabled clocks follow (default 4). After that, `cclk_en` goes to 0 and `mem_addr` returns to 0.
- R6: If `init_n` is 0 during shifting, then on the next cycle `cclk_en` is 0, `mem_addr` is 0 and `prog_n` is 0. `prog_n` is low for exactly one cycle.
- R7: After an abort, the next load restarts from byte 0 and the full stream is delivered correctly.
- R8: `cclk` is always the inversion of `clk`. `cclk_en` is 0 whenever the loader is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_n | input | 1 | Target ready line; 0 means not ready or configuration error |
| done_in | input | 1 | Target configuration-complete line |
| mem_data | input | DATA_W | Byte read from memory at `mem_addr` (asynchronous read) |
| mem_addr | output | ADDR_W | Memory byte address |
| prog_n | output | 1 | Active-low program/restart pulse to the target |
| sdo | output | 1 | Serial configuration data |
| cclk | output | 1 | Configuration clock, inverted `clk` |
| cclk_en | output | 1 | Output enable for the external clock driver |

## Verification
A wrong nibble phase or a stale holding register shows up as a wrong bit in the first byte boundary the bench receives. It is seen within four to eight clocks of the fault. An address counter that steps at the wrong point shows at the target model on the very bit where the address no longer matches its nibble. A wrong abort or tail count shows on `prog_n` or `cclk_en` on the cycle after `init_n` drops, or after the fourth extra clock following `done_in`.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_TAIL = 2'b01,
    ST_SHB  = 2'b10,
    ST_SHA  = 2'b11
  } ld_state_e;
endpackage

// File: rtl/cfgld_fsm.sv
module cfgld_fsm
  import cfgld_pkg::*;
#(
  parameter int NIB_BITS  = 4,
  parameter int TAIL_CLKS = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      init_n,
  input  logic      done_in,
  output ld_state_e state,
  output ld_state_e nxt,
  output logic      prog_n,
  output logic      clk_en
);
  localparam int MAXC = (NIB_BITS > TAIL_CLKS) ? NIB_BITS : TAIL_CLKS;
  localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] NIB_LAST  = CW'(NIB_BITS - 1);
  localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_CLKS - 1);

  logic [CW-1:0] cnt;
  logic shifting, abort, nib_end, tail_end;

  assign shifting = (state == ST_SHA) || (state == ST_SHB);
  assign abort    = shifting && !init_n;
  assign nib_end  = (cnt == NIB_LAST);
  assign tail_end = (cnt == TAIL_LAST);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (init_n && !done_in) nxt = ST_SHA;
      ST_SHA: begin
        if (!init_n)      nxt = ST_IDLE;
        else if (done_in) nxt = ST_TAIL;
        else if (nib_end) nxt = ST_SHB;
      end
      ST_SHB: begin
        if (!init_n)      nxt = ST_IDLE;
        else if (done_in) nxt = ST_TAIL;
        else if (nib_end) nxt = ST_SHA;
      end
      ST_TAIL: if (tail_end) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      prog_n <= 1'b1;
      clk_en <= 1'b0;
    end else begin
      state  <= nxt;
      cnt    <= (nxt != state || nxt == ST_IDLE) ? '0 : cnt + 1'b1;
      prog_n <= !abort;
      clk_en <= (nxt != ST_IDLE);
    end
  end

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (shifting && !init_n) |=> (state == ST_IDLE && !prog_n && !clk_en));
  // R6
  prog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_n |=> prog_n);
  // R5
  tail_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (shifting && init_n && done_in) |=> (state == ST_TAIL && clk_en));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !(init_n && !done_in)) |=> (state == ST_IDLE && !clk_en));
  // R3
  nibble_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHA && nib_end && init_n && !done_in) |=> (state == ST_SHB));
endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter
  import cfgld_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ld_state_e         state,
  input  ld_state_e         nxt,
  input  logic [DATA_W-1:0] mem_data,
  output logic              sdo
);
  localparam int NIB = DATA_W / 2;

  logic [NIB-1:0] bus_lo, bus_hi;
  logic [NIB-1:0] d_lo, d_hi;

  assign d_lo = mem_data[NIB-1:0];
  assign d_hi = mem_data[DATA_W-1:NIB];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_lo <= '0;
      bus_hi <= '0;
      sdo    <= 1'b1;
    end else if (nxt != ST_SHA && nxt != ST_SHB) begin
      sdo <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          sdo    <= d_lo[0];
          bus_lo <= d_lo >> 1;
          bus_hi <= d_hi;
        end
        ST_SHA: begin
          if (nxt == ST_SHB) begin
            sdo    <= bus_hi[0];
            bus_hi <= bus_hi >> 1;
          end else begin
            sdo    <= bus_lo[0];
            bus_lo <= bus_lo >> 1;
            bus_hi <= d_hi;
          end
        end
        ST_SHB: begin
          if (nxt == ST_SHA) begin
            sdo    <= bus_lo[0];
            bus_lo <= bus_lo >> 1;
          end else begin
            sdo    <= bus_hi[0];
            bus_hi <= bus_hi >> 1;
            bus_lo <= d_lo;
          end
        end
        default: sdo <= 1'b1;
      endcase
    end
  end

  // R8
  sdo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> sdo);
endmodule

// File: rtl/cfgld_addr.sv
module cfgld_addr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst || clr) addr <= '0;
    else if (inc)   addr <= addr + 1'b1;
  end

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(addr));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc) |=> (addr == $past(addr) + 1'b1));
  // R7
  addr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (addr == '0));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgld_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int TAIL_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_n,
  input  logic              done_in,
  input  logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              prog_n,
  output logic              sdo,
  output logic              cclk,
  output logic              cclk_en
);
  localparam int NIB_BITS = DATA_W / 2;

  ld_state_e state, nxt;

  cfgld_fsm #(.NIB_BITS(NIB_BITS), .TAIL_CLKS(TAIL_CLKS)) u_fsm (
    .clk(clk), .rst(rst), .init_n(init_n), .done_in(done_in),
    .state(state), .nxt(nxt), .prog_n(prog_n), .clk_en(cclk_en)
  );

  cfgld_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .state(state), .nxt(nxt),
    .mem_data(mem_data), .sdo(sdo)
  );

  cfgld_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst),
    .clr(nxt == ST_IDLE),
    .inc(state == ST_SHA && nxt == ST_SHB),
    .addr(mem_addr)
  );

  assign cclk = ~clk;

  // R8
  idle_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !cclk_en);
endmodule

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, init_n = 1'b0, done_in = 1'b0;
  logic [7:0]  mem_data;
  logic [15:0] mem_addr;
  logic prog_n, sdo, cclk, cclk_en;
  logic [7:0] mem [0:63];

  int checks = 0, failures = 0;
  int tgt_bits = 0, rx_n = 0, tail_n = 0, addr_err = 0;
  bit rx [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_data = mem[mem_addr[5:0]];

  cfg_serial_loader u0 (
    .clk(clk), .rst(rst), .init_n(init_n), .done_in(done_in),
    .mem_data(mem_data), .mem_addr(mem_addr), .prog_n(prog_n),
    .sdo(sdo), .cclk(cclk), .cclk_en(cclk_en)
  );

  // target model: samples on cclk rising (clk falling)
  always @(negedge clk) begin
    if (!rst && cclk_en) begin
      if (!done_in) begin
        rx[rx_n] = sdo;
        if (int'(mem_addr) != rx_n / 8 + (((rx_n % 8) >= 4) ? 1 : 0)) addr_err++;
        rx_n++;
        if (rx_n == tgt_bits) done_in = 1'b1;
      end else begin
        tail_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic fill_mem(input int seed);
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * seed * 7 + seed + i * 3);
  endtask

  task automatic clear_model(input int nbits);
    tgt_bits = nbits; rx_n = 0; tail_n = 0; addr_err = 0; done_in = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!(done_in && !cclk_en) && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  function automatic int bit_errs();
    int e = 0;
    for (int i = 0; i < rx_n; i++) if (rx[i] != mem[i / 8][i % 8]) e++;
    return e;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(prog_n == 1'b1, "R1 prog_n", int'(prog_n), 1);
    chk(cclk_en == 1'b0, "R1 cclk_en", int'(cclk_en), 0);
    chk(mem_addr == 16'd0, "R1 mem_addr", int'(mem_addr), 0);
    chk(cclk == ~clk, "R8 cclk inverted", int'(cclk), int'(~clk));
  endtask

  task automatic t_idle_hold();
    int en_seen = 0;
    init_n = 1'b0; done_in = 1'b0;
    repeat (10) begin @(negedge clk); if (cclk_en) en_seen++; end
    chk(en_seen == 0, "R2 idle with init_n=0", en_seen, 0);
    chk(mem_addr == 16'd0, "R2 addr idle", int'(mem_addr), 0);
  endtask

  task automatic t_load(input int nbits, input int seed, input string tag);
    int en_seen = 0;
    fill_mem(seed);
    clear_model(nbits);
    @(negedge clk);
    init_n = 1'b1;
    wait_done();
    chk(rx_n == nbits, {"R3 bit count ", tag}, rx_n, nbits);
    chk(bit_errs() == 0, {"R3 bit errors ", tag}, bit_errs(), 0);
    chk(addr_err == 0, {"R4 address per nibble ", tag}, addr_err, 0);
    chk(tail_n == 4, {"R5 tail clocks ", tag}, tail_n, 4);
    chk(mem_addr == 16'd0, {"R5 addr after done ", tag}, int'(mem_addr), 0);
    // done stays high: no new load must start
    repeat (8) begin @(negedge clk); if (cclk_en) en_seen++; end
    chk(en_seen == 0, {"R2 no start with done_in=1 ", tag}, en_seen, 0);
    chk(cclk_en == 1'b0, {"R8 idle clock disabled ", tag}, int'(cclk_en), 0);
    init_n = 1'b0; done_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_restart();
    int n = 0;
    fill_mem(5);
    clear_model(48);
    @(negedge clk);
    init_n = 1'b1;
    while (rx_n < 21 && n < 2000) begin @(negedge clk); n++; end
    init_n = 1'b0;
    @(negedge clk);
    chk(prog_n == 1'b0, "R6 prog_n low after abort", int'(prog_n), 0);
    chk(cclk_en == 1'b0, "R6 clock off after abort", int'(cclk_en), 0);
    chk(mem_addr == 16'd0, "R6 addr cleared", int'(mem_addr), 0);
    @(negedge clk);
    chk(prog_n == 1'b1, "R6 prog_n one-cycle pulse", int'(prog_n), 1);
    repeat (3) @(negedge clk);
    chk(cclk_en == 1'b0, "R2 held idle while init_n=0", int'(cclk_en), 0);
    clear_model(48);
    init_n = 1'b1;
    wait_done();
    chk(rx_n == 48, "R7 restart bit count", rx_n, 48);
    chk(bit_errs() == 0, "R7 restart from byte 0", bit_errs(), 0);
    chk(addr_err == 0, "R7 restart addresses", addr_err, 0);
    init_n = 1'b0; done_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle_hold();
    t_load(40, 3, "byte end");
    t_load(36, 11, "ends in low nibble");
    t_load(46, 29, "ends mid high nibble");
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule